// File: doc/BRIEF.md
# Burst-of-Two Separate-Port DDR SRAM

This block is an on-chip memory with one read port and one write port that behave like a burst-of-two, double-data-rate synchronous SRAM. A single fabric clock runs at twice the command rate. An internal phase bit, brought out as `k_phase`, splits each command period into a command half (`k_phase` = 0) and a second half (`k_phase` = 1). Commands are sampled only on the clock edge that ends a command half. Each accepted command moves two words: the addressed word and the one above it, modulo the depth.

A read burst returns its two words on `q` after a fixed delay of whole command periods. `q_valid` marks both beats, and the echo strobe `cq` marks the first beat. A write burst takes its two data beats on the two edges that follow the command. Each beat carries its own active-low byte mask. Both ports can start a new burst every command period. A burst in progress always runs to the end, and neither port can disturb the other.

Read state machine: RD_IDLE, RD_BEAT0, RD_BEAT1. On a command edge, a read that was accepted on the previous command edge moves the machine to RD_BEAT0 (RD_IDLE → RD_BEAT0 or RD_BEAT1 → RD_BEAT0). With no such read it moves to RD_IDLE. On the following edge RD_BEAT0 → RD_BEAT1. Write state machine: WR_IDLE → WR_BEAT0 on an accepted write, WR_BEAT0 → WR_BEAT1 unconditionally, and WR_BEAT1 → WR_BEAT0 (a chained write) or WR_BEAT1 → WR_IDLE.

Top module: `qdr_b2_sram`

## Requirements
- R1: Read and write commands (`rd_n`, `rd_addr`, `wr_n`, `wr_addr`) are sampled only on clock edges where `k_phase` = 0. Any value on them while `k_phase` = 1 has no effect.
- R2: `rd_n` = 0 at a command edge starts a read of address A. `q` shows word A after the second clock edge following that command edge. `q` shows word A+1 (modulo depth) one clock later.
- R3: `q_valid` is 1 on exactly the two read beats. `cq` is 1 on the first beat only. When no beat is due, `q` = 0, `q_valid` = 0 and `cq` = 0.
- R4: `rd_n` = 1 at a command edge starts no burst. With both enables high the memory contents do not change.
- R5: `wr_n` = 0 at a command edge latches address B. On the next edge `wr_data` is written to B. On the edge after that, `wr_data` is written to B+1 (modulo depth). `wr_be_n` bit i = 0 enables byte i (bits 8i+7..8i) for that beat.
- R6: Each port accepts a new command on every command edge. Back-to-back bursts neither truncate nor restart one another, and a read and a write on the same edge both complete.
- R7: A read returns the effect of every write issued on the same command edge or earlier, including a write whose second beat lands on the read's first address on the same edge (forwarded). A write issued on a later command edge is not seen.
- R8: During and after reset, `k_phase` = 0, both ports are idle and the outputs are idle. After reset, `k_phase` toggles on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, twice the command rate |
| rst_n | input | 1 | Active-low synchronous reset |
| k_phase | output | 1 | 0 = command half, 1 = second half |
| rd_n | input | 1 | Active-low read command |
| rd_addr | input | AW | Read burst start address |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | AW | Write burst start address |
| wr_data | input | 8*NB | Write data beat |
| wr_be_n | input | NB | Active-low byte enables for the current beat |
| q | output | 8*NB | Read data beat, 0 when idle |
| q_valid | output | 1 | High on both read beats |
| cq | output | 1 | Echo strobe, high on the first read beat |

## Verification
A read accepted on command edge E shows its first word after edge E+2 and its second word after edge E+3. The bench therefore samples on falling edges: the first beat in the second half of the next command period, and the second beat at the start of the period after that. Write beats are driven on the falling edge before the edge that captures them. Each read's expected pair is taken from a reference array at issue time, after that period's write has been applied in full, which is exactly the visibility rule R7 sets. During every second half the bench drives low enables and altered addresses, so any sampling outside the command half shows up as wrong read data.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_BEAT0 = 2'd1,
        RD_BEAT1 = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_BEAT0 = 2'd1,
        WR_BEAT1 = 2'd2
    } wr_state_e;
endpackage

// File: rtl/qdr_b2_mem.sv
module qdr_b2_mem #(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [8*NB-1:0] wdata,
    input  logic [NB-1:0]   wbe_n,
    input  logic [AW-1:0]   raddr,
    output logic [8*NB-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = 8 * NB;

    logic [DW-1:0] store [DEPTH];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && !wbe_n[b]) begin
                store[waddr][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/qdr_b2_wr_port.sv
module qdr_b2_wr_port
    import qdr_b2_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic            wr_n,
    input  logic [AW-1:0]   wr_addr,
    input  logic [8*NB-1:0] wr_data,
    input  logic [NB-1:0]   wr_be_n,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [8*NB-1:0] mem_data,
    output logic [NB-1:0]   mem_be_n,
    output logic            beat1
);
    wr_state_e     st;
    logic [AW-1:0] b_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= WR_IDLE;
            b_addr <= '0;
        end else begin
            unique case (st)
                WR_IDLE: begin
                    if (!k_phase && !wr_n) begin
                        st     <= WR_BEAT0;
                        b_addr <= wr_addr;
                    end
                end
                WR_BEAT0: st <= WR_BEAT1;
                WR_BEAT1: begin
                    if (!wr_n) begin
                        st     <= WR_BEAT0;
                        b_addr <= wr_addr;
                    end else begin
                        st <= WR_IDLE;
                    end
                end
                default: st <= WR_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_data = wr_data;
        mem_be_n = wr_be_n;
        unique case (st)
            WR_BEAT0: begin
                mem_we   = 1'b1;
                mem_addr = b_addr;
                beat1    = 1'b0;
            end
            WR_BEAT1: begin
                mem_we   = 1'b1;
                mem_addr = b_addr + AW'(1);
                beat1    = 1'b1;
            end
            default: begin
                mem_we   = 1'b0;
                mem_addr = b_addr;
                beat1    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qdr_b2_rd_port.sv
module qdr_b2_rd_port
    import qdr_b2_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            k_phase,
    input  logic            rd_n,
    input  logic [AW-1:0]   rd_addr,
    output logic [AW-1:0]   mem_addr,
    input  logic [8*NB-1:0] mem_word,
    input  logic            fwd_en,
    input  logic [AW-1:0]   fwd_addr,
    input  logic [8*NB-1:0] fwd_data,
    input  logic [NB-1:0]   fwd_be_n,
    output logic [8*NB-1:0] q,
    output logic            q_valid,
    output logic            cq
);
    localparam int DW = 8 * NB;

    rd_state_e     st;
    logic          pend_vld;
    logic [AW-1:0] pend_addr;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] word;
    logic [DW-1:0] q_r;
    logic          fwd_hit;

    assign mem_addr = k_phase ? cur_addr + AW'(1) : pend_addr;
    assign fwd_hit  = !k_phase && fwd_en && (fwd_addr == pend_addr);

    for (genvar b = 0; b < NB; b++) begin : g_fwd
        assign word[8*b +: 8] = (fwd_hit && !fwd_be_n[b]) ? fwd_data[8*b +: 8]
                                                          : mem_word[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= RD_IDLE;
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            cur_addr  <= '0;
        end else if (!k_phase) begin
            pend_vld  <= ~rd_n;
            pend_addr <= rd_addr;
            if (pend_vld) begin
                st       <= RD_BEAT0;
                cur_addr <= pend_addr;
            end else begin
                st <= RD_IDLE;
            end
        end else begin
            st <= (st == RD_BEAT0) ? RD_BEAT1 : RD_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (!k_phase) begin
            q_r <= pend_vld ? word : '0;
        end else begin
            q_r <= (st == RD_BEAT0) ? word : '0;
        end
    end

    always_comb begin
        q = q_r;
        unique case (st)
            RD_BEAT0: begin
                q_valid = 1'b1;
                cq      = 1'b1;
            end
            RD_BEAT1: begin
                q_valid = 1'b1;
                cq      = 1'b0;
            end
            default: begin
                q_valid = 1'b0;
                cq      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            k_phase,
    input  logic            rd_n,
    input  logic [AW-1:0]   rd_addr,
    input  logic            wr_n,
    input  logic [AW-1:0]   wr_addr,
    input  logic [8*NB-1:0] wr_data,
    input  logic [NB-1:0]   wr_be_n,
    output logic [8*NB-1:0] q,
    output logic            q_valid,
    output logic            cq
);
    localparam int DW = 8 * NB;

    logic          phase_r;
    logic          w_we;
    logic [AW-1:0] w_addr;
    logic [DW-1:0] w_data;
    logic [NB-1:0] w_be_n;
    logic          w_beat1;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_word;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_r <= 1'b0;
        else        phase_r <= ~phase_r;
    end
    assign k_phase = phase_r;

    qdr_b2_wr_port #(.AW(AW), .NB(NB)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_phase  (phase_r),
        .wr_n     (wr_n),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be_n  (wr_be_n),
        .mem_we   (w_we),
        .mem_addr (w_addr),
        .mem_data (w_data),
        .mem_be_n (w_be_n),
        .beat1    (w_beat1)
    );

    qdr_b2_mem #(.AW(AW), .NB(NB)) u_mem (
        .clk   (clk),
        .we    (w_we),
        .waddr (w_addr),
        .wdata (w_data),
        .wbe_n (w_be_n),
        .raddr (r_addr),
        .rdata (r_word)
    );

    qdr_b2_rd_port #(.AW(AW), .NB(NB)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_phase  (phase_r),
        .rd_n     (rd_n),
        .rd_addr  (rd_addr),
        .mem_addr (r_addr),
        .mem_word (r_word),
        .fwd_en   (w_beat1),
        .fwd_addr (w_addr),
        .fwd_data (w_data),
        .fwd_be_n (w_be_n),
        .q        (q),
        .q_valid  (q_valid),
        .cq       (cq)
    );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          k_phase,
    input logic          rd_n,
    input logic [DW-1:0] q,
    input logic          q_valid,
    input logic          cq
);
    assert_phase_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (k_phase != $past(k_phase)));

    assert_read_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !k_phase) |=> ##2 cq);

    assert_deselect_no_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && !k_phase) |=> ##2 !q_valid);

    assert_second_beat_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cq |=> (q_valid && !cq));

    assert_strobe_in_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cq |-> q_valid);

    assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q == '0));

    assert_beat_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cq |-> k_phase);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.DW(8*NB)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_phase (k_phase),
    .rd_n    (rd_n),
    .q       (q),
    .q_valid (q_valid),
    .cq      (cq)
);

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;
    localparam int AW    = 4;
    localparam int NB    = 2;
    localparam int DW    = 8 * NB;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_phase;
    logic          rd_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] wr_be_n = '1;
    logic [DW-1:0] q;
    logic          q_valid;
    logic          cq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] prev_d1  = '0;
    logic [NB-1:0] prev_be1 = '1;
    logic          o_v = 1'b0, p_v = 1'b0;
    logic [DW-1:0] o_e0 = '0, o_e1 = '0, p_e0 = '0, p_e1 = '0;

    always #4 clk = ~clk;

    qdr_b2_sram #(.AW(AW), .NB(NB)) dut (
        .clk(clk), .rst_n(rst_n), .k_phase(k_phase),
        .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .q(q), .q_valid(q_valid), .cq(cq)
    );

    task automatic chk(input string tag, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NB-1:0] be_n);
        logic [DW-1:0] r;
        r = old;
        for (int b = 0; b < NB; b++) if (!be_n[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // One command period, entered at the falling edge before a command edge.
    task automatic step(input string tag, input logic rn, input logic [AW-1:0] ra,
                        input logic wn, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d0, input logic [NB-1:0] b0,
                        input logic [DW-1:0] d1, input logic [NB-1:0] b1);
        logic [AW-1:0] wa1;
        logic [AW-1:0] ra1;
        chk({tag, " beat1"}, {q_valid, cq, q}, {o_v, 1'b0, o_v ? o_e1 : '0});
        rd_n = rn; rd_addr = ra; wr_n = wn; wr_addr = wa;
        wr_data = prev_d1; wr_be_n = prev_be1;
        wa1 = wa + AW'(1);
        ra1 = ra + AW'(1);
        if (!wn) begin
            model[wa]  = merge(model[wa], d0, b0);
            model[wa1] = merge(model[wa1], d1, b1);
        end
        o_v = p_v; o_e0 = p_e0; o_e1 = p_e1;
        p_v = !rn; p_e0 = model[ra]; p_e1 = model[ra1];
        prev_d1  = wn ? '0 : d1;
        prev_be1 = wn ? '1 : b1;
        @(negedge clk);
        chk({tag, " beat0"}, {q_valid, cq, q}, {o_v, o_v, o_v ? o_e0 : '0});
        // R1: enables low and altered addresses in the second half must be ignored
        rd_n = 1'b0; wr_n = 1'b0; rd_addr = ~ra; wr_addr = ~wa;
        wr_data = d0; wr_be_n = wn ? '1 : b0;
        @(negedge clk);
    endtask

    task automatic nop(input string tag);
        step(tag, 1'b1, '0, 1'b1, '0, '0, '1, '0, '1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        chk("R8 reset", {k_phase, q_valid, cq, q}, '0);
        rst_n = 1'b1;
        chk("R8 phase after release", {1'b0, k_phase}, '0);
        nop("R3 idle");
        nop("R3 idle");

        // R5: fill every address with chained writes; R6 back-to-back
        for (int a = 0; a < DEPTH; a++)
            step("R5 R6 fill", 1'b1, '0, 1'b0, AW'(a),
                 DW'(a * 16'h0111 + 16'h2300), '0, DW'(a * 16'h0203 + 16'h8001), '0);
        // R2 R6: back-to-back reads over every address including wrap
        for (int a = 0; a < DEPTH; a++)
            step("R2 R6 sweep", 1'b0, AW'(a), 1'b1, '0, '0, '1, '0, '1);
        nop("R3 drain");
        nop("R3 drain");

        // alternating read / nop / write pattern
        for (int i = 0; i < 6; i++) begin
            step("R2 alt read", 1'b0, AW'(3 * i + 1), 1'b1, '0, '0, '1, '0, '1);
            nop("R4 alt nop");
            step("R6 alt write", 1'b1, '0, 1'b0, AW'(5 * i + 2),
                 DW'(16'hA000 + i), '0, DW'(16'hB000 + i), '0);
            step("R6 alt both", 1'b0, AW'(7 * i), 1'b0, AW'(2 * i + 9),
                 DW'(16'hC000 + 16'h0011 * i), '0, DW'(16'hD000 + i), '0);
        end

        // R5: byte masks per beat
        step("R5 mask", 1'b1, '0, 1'b0, 4'd4, 16'h1234, 2'b01, 16'h5678, 2'b10);
        step("R5 mask rd", 1'b0, 4'd4, 1'b0, 4'd14, 16'hEEFF, 2'b10, 16'h99AA, 2'b11);
        step("R5 mask rd", 1'b0, 4'd14, 1'b1, '0, '0, '1, '0, '1);

        // R7: read same edge as write; second beat forwarded onto read start
        step("R7 fwd", 1'b0, 4'd7, 1'b0, 4'd6, 16'h0F0F, 2'b00, 16'hF00D, 2'b00);
        step("R7 fwd", 1'b0, 4'd6, 1'b0, 4'd8, 16'h4242, 2'b00, 16'h2424, 2'b01);
        step("R7 later write", 1'b0, 4'd9, 1'b0, 4'd10, 16'h7777, 2'b00, 16'h6666, 2'b00);
        step("R7 fwd wrap", 1'b0, 4'd0, 1'b0, 4'd15, 16'h3131, 2'b00, 16'h1313, 2'b00);

        // R4: deselect both ports, then confirm contents unchanged
        nop("R4 deselect");
        nop("R4 deselect");
        for (int a = 0; a < DEPTH; a += 2)
            step("R4 readback", 1'b0, AW'(a), 1'b1, '0, '0, '1, '0, '1);
        nop("R1 drain");
        nop("R1 drain");
        nop("R3 drain");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule